// File: doc/BRIEF.md
# Dual-Clock Word Crossing Queue

This block is a small first-in first-out queue that moves data words from a producer running on one clock to a consumer running on a second, unrelated clock. The producer offers a word with a push strobe and watches a full flag. The consumer always sees the oldest stored word on a head output while the empty flag is low. It removes that word with a separate pop strobe, so it can inspect the head without consuming it.

Each side counts its own position with a binary pointer one bit wider than the storage address. Each side also keeps a registered Gray-coded copy of that pointer. Only the Gray copy travels to the other side, through a two-stage synchronizer. Because a flag can only react after the other side's pointer has crossed, both flags are pessimistic: full can stay high after space has been freed, and empty can stay high after a word has been written. The design stays correct at a storage depth of two, which is the size used between pipeline stages that run at different rates.

Each side is a two-state machine. The write side has the states WR_ROOM (pushes accepted) and WR_FULL (pushes dropped). The read side has the states RD_DRY (nothing visible, pops dropped) and RD_READY (head valid, pops accepted). On every edge, each machine computes its next state from its own next pointer and the synchronized pointer of the other side:
- Write side: WR_ROOM→WR_FULL on the edge that accepts the filling push. WR_FULL→WR_ROOM once the freed slot is seen through the synchronizer.
- Read side: RD_READY→RD_DRY on the edge that pops the last visible word. RD_DRY→RD_READY once a new word is seen through the synchronizer.

Top module: `xclk_fifo`

## Requirements
- R1: An active-low reset on either side is asynchronous. While the write reset is asserted, `wr_full` is 0. While the read reset is asserted, `rd_empty` is 1, with no clock edge needed.
- R2: Words leave in the order they were accepted. Whenever `rd_empty` is 0, `rd_head` shows the oldest accepted word that has not been popped.
- R3: While `rd_pop` is low, the head word is not removed: `rd_head` and `rd_empty` keep their values across read clock cycles.
- R4: A push while `wr_full` is 1 is dropped. The word is never delivered and the write pointer does not move.
- R5: A pop while `rd_empty` is 1 is dropped. The read pointer does not move, so the next word written becomes the head.
- R6: The write edge that accepts the DEPTH-th unread word sets `wr_full` (state WR_FULL). With fewer unread words, `wr_full` stays 0.
- R7: After a pop frees a slot in a full queue, `wr_full` stays 1 for at least one further write clock edge. It returns to 0 within eight write clock cycles.
- R8: After a word is written into an empty queue, `rd_empty` stays 1 for at least one further read clock edge. It returns to 0 within eight read clock cycles.
- R9: Each Gray pointer sent across changes in at most one bit per clock of its own domain.
- R10: With DEPTH equal to 2 and the two clocks at different rates, a stream with mixed gaps on both sides arrives complete and in order.
- R11: `wr_full` rises only after an accepted push, and `rd_empty` rises only after an accepted pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, producer side |
| wr_push | input | 1 | Request to store `wr_data` |
| wr_data | input | W | Word to store |
| wr_full | output | 1 | Queue full, pessimistic; pushes dropped while high |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, consumer side |
| rd_pop | input | 1 | Remove the head word |
| rd_head | output | W | Oldest stored word, valid while `rd_empty` is 0 |
| rd_empty | output | 1 | Queue empty, pessimistic; pops dropped while high |

## Verification
The bench fills a two-entry queue and pushes once more while it is full. A design that let that push through would deliver a third word, or would wrap the write pointer and make the queue look empty. The bench pops while empty and then writes one word. A read pointer that slipped would show a stale slot as the head instead of that word. It holds the head without popping, to catch a design that consumes on read. It also samples each flag one edge after the opposite side has moved, which exposes a flag computed without the synchronizer delay. Finally, it runs a stream with mixed gaps on both sides, which catches a wrong full comparison at the smallest depth as lost or duplicated words.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

    // Write-side machine: room available, or every slot holds an unread word.
    typedef enum logic {
        WR_ROOM = 1'b0,
        WR_FULL = 1'b1
    } wr_state_e;

    // Read-side machine: nothing visible yet, or a valid head word.
    typedef enum logic {
        RD_DRY   = 1'b0,
        RD_READY = 1'b1
    } rd_state_e;

endpackage

// File: rtl/xfifo_sync2.sv
module xfifo_sync2 #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[g] <= '0;
                else        stage[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[g] <= '0;
                else        stage[g] <= stage[g-1];
            end
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/xfifo_store.sv
module xfifo_store #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/xfifo_wr_ctrl.sv
module xfifo_wr_ctrl
    import xfifo_pkg::*;
#(
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW:0]   rgray_sync,
    output logic          accept,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          full
);

    localparam int PW = AW + 1;
    // A full queue differs from the reader by exactly one lap: in Gray code,
    // the two top bits are inverted and the rest match.
    localparam logic [AW:0] LAP_MASK = PW'(3) << (AW - 1);

    wr_state_e   state, state_nx;
    logic [AW:0] wbin, wbin_nx, wgray_nx;

    always_comb begin
        unique case (state)
            WR_ROOM: accept = push;
            WR_FULL: accept = 1'b0;
            default: accept = 1'b0;
        endcase
        wbin_nx  = wbin + PW'(accept);
        wgray_nx = wbin_nx ^ (wbin_nx >> 1);
        state_nx = (wgray_nx == (rgray_sync ^ LAP_MASK)) ? WR_FULL : WR_ROOM;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WR_ROOM;
            wbin  <= '0;
            wgray <= '0;
        end else begin
            state <= state_nx;
            wbin  <= wbin_nx;
            wgray <= wgray_nx;
        end
    end

    always_comb begin
        full  = (state == WR_FULL);
        waddr = wbin[AW-1:0];
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> $stable(wbin));

    assert_wgray_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wgray ^ $past(wgray)));

    assert_full_after_push_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(push));

endmodule

// File: rtl/xfifo_rd_ctrl.sv
module xfifo_rd_ctrl
    import xfifo_pkg::*;
#(
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic [AW:0]   wgray_sync,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          empty
);

    localparam int PW = AW + 1;

    rd_state_e   state, state_nx;
    logic [AW:0] rbin, rbin_nx, rgray_nx;
    logic        take;

    always_comb begin
        unique case (state)
            RD_READY: take = pop;
            RD_DRY:   take = 1'b0;
            default:  take = 1'b0;
        endcase
        rbin_nx  = rbin + PW'(take);
        rgray_nx = rbin_nx ^ (rbin_nx >> 1);
        state_nx = (rgray_nx == wgray_sync) ? RD_DRY : RD_READY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RD_DRY;
            rbin  <= '0;
            rgray <= '0;
        end else begin
            state <= state_nx;
            rbin  <= rbin_nx;
            rgray <= rgray_nx;
        end
    end

    always_comb begin
        empty = (state == RD_DRY);
        raddr = rbin[AW-1:0];
    end

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> $stable(rbin));

    assert_rgray_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rgray ^ $past(rgray)));

    assert_empty_after_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(empty) |-> $past(pop));

endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         wr_clk,
    input  logic         wr_rst_n,
    input  logic         wr_push,
    input  logic [W-1:0] wr_data,
    output logic         wr_full,
    input  logic         rd_clk,
    input  logic         rd_rst_n,
    input  logic         rd_pop,
    output logic [W-1:0] rd_head,
    output logic         rd_empty
);

    localparam int AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          w_accept;
    logic [AW-1:0] w_addr, r_addr;
    logic [AW:0]   w_gray, r_gray, w_gray_at_rd, r_gray_at_wr;

    xfifo_wr_ctrl #(.AW(AW)) u_wr (
        .clk        (wr_clk),
        .rst_n      (wr_rst_n),
        .push       (wr_push),
        .rgray_sync (r_gray_at_wr),
        .accept     (w_accept),
        .waddr      (w_addr),
        .wgray      (w_gray),
        .full       (wr_full)
    );

    xfifo_sync2 #(.W(PW), .STAGES(2)) u_r2w (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (r_gray),
        .q     (r_gray_at_wr)
    );

    xfifo_sync2 #(.W(PW), .STAGES(2)) u_w2r (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (w_gray),
        .q     (w_gray_at_rd)
    );

    xfifo_rd_ctrl #(.AW(AW)) u_rd (
        .clk        (rd_clk),
        .rst_n      (rd_rst_n),
        .pop        (rd_pop),
        .wgray_sync (w_gray_at_rd),
        .raddr      (r_addr),
        .rgray      (r_gray),
        .empty      (rd_empty)
    );

    xfifo_store #(.W(W), .DEPTH(1 << AW)) u_mem (
        .wclk  (wr_clk),
        .we    (w_accept),
        .waddr (w_addr),
        .wdata (wr_data),
        .raddr (r_addr),
        .rdata (rd_head)
    );

endmodule

// File: tb/test_xclk_fifo.sv
module test_xclk_fifo;

    localparam int W     = 8;
    localparam int DEPTH = 2;
    // Each entry: {data[15:8], write gap[7:4], read gap[3:0]}
    localparam logic [15:0] VEC [12] = '{
        16'h3C00, 16'h5A10, 16'h0F02, 16'hF030, 16'h1101, 16'h2200,
        16'h8743, 16'h4405, 16'hE700, 16'h9950, 16'h6601, 16'hC300
    };

    logic         wr_clk = 0, rd_clk = 0;
    logic         wr_rst_n = 0, rd_rst_n = 0;
    logic         wr_push = 0, rd_pop = 0;
    logic [W-1:0] wr_data = '0;
    logic         wr_full, rd_empty;
    logic [W-1:0] rd_head;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5   wr_clk = ~wr_clk;   // 100 MHz
    always #6.5 rd_clk = ~rd_clk;

    xclk_fifo #(.W(W), .DEPTH(DEPTH)) i_xclk_fifo (
        .wr_clk, .wr_rst_n, .wr_push, .wr_data, .wr_full,
        .rd_clk, .rd_rst_n, .rd_pop, .rd_head, .rd_empty
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_word(input logic [W-1:0] d);
        @(negedge wr_clk);
        wr_push = 1; wr_data = d;
        @(negedge wr_clk);
        wr_push = 0;
    endtask

    task automatic pop_word();
        @(negedge rd_clk);
        rd_pop = 1;
        @(negedge rd_clk);
        rd_pop = 0;
    endtask

    task automatic wait_not_empty(input string tag);
        bit seen = 0;
        for (int k = 0; k < 8 && !seen; k++) begin
            @(negedge rd_clk);
            if (!rd_empty) seen = 1;
        end
        chk(tag, seen, 1);
    endtask

    initial begin
        repeat (20000) @(posedge wr_clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: flags under reset, no edge needed
        #2;
        chk("R1 full in reset", wr_full, 0);
        chk("R1 empty in reset", rd_empty, 1);
        #30;
        wr_rst_n = 1; rd_rst_n = 1;
        repeat (3) @(negedge wr_clk);
        chk("R1 full after reset", wr_full, 0);

        // R6 / R8: fill the two-entry queue
        push_word(8'h11);
        chk("R6 one word not full", wr_full, 0);
        @(negedge rd_clk);
        chk("R8 empty still set after write", rd_empty, 1);
        push_word(8'h22);
        chk("R6 full at depth", wr_full, 1);
        wait_not_empty("R8 empty clears");
        chk("R2 head is first word", rd_head, 8'h11);

        // R3: peek without popping
        repeat (3) @(negedge rd_clk);
        chk("R3 head held", rd_head, 8'h11);
        chk("R3 still not empty", rd_empty, 0);

        // R4: push while full is dropped
        push_word(8'h33);
        chk("R4 full held after dropped push", wr_full, 1);

        // R7: pop frees a slot, full lags
        pop_word();
        chk("R2 head advances", rd_head, 8'h22);
        @(negedge wr_clk);
        chk("R7 full still set after pop", wr_full, 1);
        begin
            bit cleared = 0;
            for (int k = 0; k < 8 && !cleared; k++) begin
                @(negedge wr_clk);
                if (!wr_full) cleared = 1;
            end
            chk("R7 full clears", cleared, 1);
        end
        pop_word();
        chk("R11 empty after last pop", rd_empty, 1);
        repeat (10) @(negedge rd_clk);
        chk("R4 dropped word never appears", rd_empty, 1);

        // R5: pops while empty are dropped
        @(negedge rd_clk); rd_pop = 1;
        repeat (4) @(negedge rd_clk);
        rd_pop = 0;
        push_word(8'hA5);
        wait_not_empty("R5 word visible");
        chk("R5 head after dropped pops", rd_head, 8'hA5);
        pop_word();
        chk("R5 empty after pop", rd_empty, 1);

        // R10 / R2: streaming through depth 2
        fork
            begin
                foreach (VEC[i]) begin
                    repeat (VEC[i][7:4]) @(negedge wr_clk);
                    @(negedge wr_clk);
                    while (wr_full) @(negedge wr_clk);
                    wr_push = 1; wr_data = VEC[i][15:8];
                    @(negedge wr_clk);
                    wr_push = 0;
                end
            end
            begin
                foreach (VEC[i]) begin
                    repeat (VEC[i][3:0]) @(negedge rd_clk);
                    @(negedge rd_clk);
                    while (rd_empty) @(negedge rd_clk);
                    chk($sformatf("R10 stream word %0d", i), rd_head, VEC[i][15:8]);
                    rd_pop = 1;
                    @(negedge rd_clk);
                    rd_pop = 0;
                end
            end
        join
        repeat (6) @(negedge rd_clk);
        chk("R10 drained", rd_empty, 1);
        chk("R10 not full", wr_full, 0);

        // R1: asynchronous reset in mid-cycle with a word stored
        push_word(8'h5E);
        wait_not_empty("R8 word visible before reset");
        #3;
        rd_rst_n = 0; wr_rst_n = 0;
        #1;
        chk("R1 async empty", rd_empty, 1);
        chk("R1 async full", wr_full, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule